// File: doc/BRIEF.md
# Dual Interval Timer with Masked Interrupt

This peripheral holds two independent down-counting interval timers behind a 32-bit register port and a single interrupt line. Each timer has a reload value and a control word. The control word picks one of eight tick-enable inputs as the timer's rate and gives the timer a command: load the reload value, hold, or run. A running timer counts down on each tick of its chosen input. When it expires it reloads itself, so it fires at a steady period.

When a timer expires it sets its own bit in a raw status register. The interrupt line is the OR of the raw status ANDed with a mask register. Software clears a status bit by writing a one to the matching bit of the acknowledge register. The tick-enable inputs come from clock-rate generators outside the block. The highest index is the fastest source.

Top module: `dual_interval_timer`

## Requirements
- R1: When reset is asserted, both timers stop. The reload values, control words, mask and raw status all read as zero and the interrupt output is low. After reset is released, no tick makes a timer expire until it is told to run.
- R2: Control bits [1:0] hold the command: 0 copies the reload value into the counter and stops the timer, 1 stops it, 2 starts it. The command acts in the clock cycle of the write, and the timer does not count in that cycle.
- R3: Control bits [4:2] hold the source index. A timer counts only on cycles where the tick input with that index is high. Ticks on any other input have no effect.
- R4: A control write with command 3 is discarded. The control word keeps its old value and the timer goes on in its current state.
- R5: After a load with reload value D (D ≥ 1), a running timer expires on its D-th selected tick. It then reloads D and expires again every D ticks after that. With D = 0 it expires on every tick.
- R6: When timer 0 expires it sets raw status bit 0, and when timer 1 expires it sets raw status bit 1. The raw status is read at offset 0x50.
- R7: Writing to offset 0x4C clears each raw status bit whose write bit is 1. Bits written 0 are unchanged. If an expiry and an acknowledge of the same bit fall in one cycle, the bit ends up set.
- R8: The interrupt output is high exactly when some raw status bit is 1 and its mask bit (offset 0x48, bits [1:0]) is also 1.
- R9: Address map. Timer 0 has its reload value at 0x00 and its control at 0x04. Timer 1 has its reload value at 0x14 and its control at 0x18. Control reads back in bits [4:0] and the reload value in full. The mask and status read back in bits [1:0]. Reads of 0x4C and of any unmapped address return zero.
- R10: A stopped timer keeps its count. A later run command carries on from that count, with no reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_src_i | input | 8 | One tick-enable input per selectable rate source |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Masked interrupt |

## Verification
Two events can land on the same raw status bit in one clock cycle: a timer expiry that sets it and an acknowledge write that clears it. The bench first brings timer 0 down to a count of one with its status bit already set. It then drives the acknowledge write for that bit and the final tick in the same cycle. After that edge the bit must still read one. A further acknowledge by itself must then clear the bit.

// File: rtl/dit_pkg.sv
package dit_pkg;

  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 3;
  localparam int NSRC    = 1 << SEL_W;
  localparam int CTRL_W  = SEL_W + 2;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } tmr_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    tmr_op_e          op;
  } tmr_ctrl_t;

  localparam int                TMR_STRIDE = 'h14;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 7'h48;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 7'h4C;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 7'h50;

  function automatic logic [ADDR_W-1:0] div_off(input int idx);
    return ADDR_W'(idx * TMR_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] ctrl_off(input int idx);
    return ADDR_W'(idx * TMR_STRIDE + 4);
  endfunction

endpackage

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  tmr_ctrl_t        ctrl_wdata,
  input  logic             div_we,
  input  logic [CNT_W-1:0] div_wdata,
  input  logic [NSRC-1:0]  tick_src_i,
  output tmr_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0] div_q,
  output logic             expire_o
);

  tmr_ctrl_t        ctrl_d;
  logic [CNT_W-1:0] div_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             run_q, run_d;
  logic             tick;
  logic             ctrl_ok;

  assign tick    = tick_src_i[ctrl_q.sel];
  assign ctrl_ok = ctrl_we && (ctrl_wdata.op != OP_BAD);

  always_comb begin
    ctrl_d   = ctrl_q;
    div_d    = div_q;
    count_d  = count_q;
    run_d    = run_q;
    expire_o = 1'b0;
    if (div_we) div_d = div_wdata;
    if (ctrl_ok) begin
      ctrl_d = ctrl_wdata;
      case (ctrl_wdata.op)
        OP_LOAD: begin
          count_d = div_q;
          run_d   = 1'b0;
        end
        OP_HOLD: run_d = 1'b0;
        OP_RUN:  run_d = 1'b1;
        default: run_d = run_q;
      endcase
    end else if (run_q && tick) begin
      if (count_q <= CNT_W'(1)) begin
        expire_o = 1'b1;
        count_d  = div_q;
      end else begin
        count_d  = count_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      count_q <= '0;
      run_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      div_q   <= div_d;
      count_q <= count_d;
      run_q   <= run_d;
    end
  end

endmodule

// File: rtl/dit_irq.sv
module dit_irq #(
  parameter int N_TMR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] expire_i,
  input  logic             mask_we,
  input  logic [N_TMR-1:0] mask_wdata,
  input  logic             ack_we,
  input  logic [N_TMR-1:0] ack_wdata,
  output logic [N_TMR-1:0] raw_q,
  output logic [N_TMR-1:0] mask_q,
  output logic             irq_o
);

  logic [N_TMR-1:0] raw_d, mask_d;

  always_comb begin
    raw_d  = raw_q;
    mask_d = mask_q;
    if (mask_we) mask_d = mask_wdata;
    if (ack_we)  raw_d  = raw_d & ~ack_wdata;
    raw_d = raw_d | expire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign irq_o = |(raw_q & mask_q);

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int N_TMR = 2,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   tick_src_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  tmr_ctrl_t [N_TMR-1:0]            ctrl_rd;
  logic      [N_TMR-1:0][CNT_W-1:0] div_rd;
  logic      [N_TMR-1:0]            expire;
  logic      [N_TMR-1:0]            raw_stat;
  logic      [N_TMR-1:0]            mask_stat;
  logic                             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    dit_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (bus_we && (bus_addr == ctrl_off(i))),
      .ctrl_wdata (tmr_ctrl_t'(bus_wdata[CTRL_W-1:0])),
      .div_we     (bus_we && (bus_addr == div_off(i))),
      .div_wdata  (bus_wdata[CNT_W-1:0]),
      .tick_src_i (tick_src_i),
      .ctrl_q     (ctrl_rd[i]),
      .div_q      (div_rd[i]),
      .expire_o   (expire[i])
    );
  end

  dit_irq #(.N_TMR(N_TMR)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire_i   (expire),
    .mask_we    (bus_we && (bus_addr == OFF_MASK)),
    .mask_wdata (bus_wdata[N_TMR-1:0]),
    .ack_we     (bus_we && (bus_addr == OFF_ACK)),
    .ack_wdata  (bus_wdata[N_TMR-1:0]),
    .raw_q      (raw_stat),
    .mask_q     (mask_stat),
    .irq_o      (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (bus_addr == div_off(i))  bus_rdata = DATA_W'(div_rd[i]);
      if (bus_addr == ctrl_off(i)) bus_rdata = DATA_W'(ctrl_rd[i]);
    end
    if (bus_addr == OFF_MASK) bus_rdata = DATA_W'(mask_stat);
    if (bus_addr == OFF_STAT) bus_rdata = DATA_W'(raw_stat);
  end

endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
#(
  parameter int N_TMR = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DATA_W-1:0]      bus_wdata,
  input logic [NSRC-1:0]        tick_src_i,
  input logic [N_TMR-1:0]       expire,
  input logic [N_TMR-1:0]       raw_stat,
  input tmr_ctrl_t [N_TMR-1:0]  ctrl_rd
);

  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    // R3: an expiry only happens on a tick of the selected source
    a_r3_tick_needed: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |-> tick_src_i[ctrl_rd[i].sel]);

    // R4: a control write with command 3 leaves the control word as it was
    a_r4_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ctrl_off(i) && bus_wdata[1:0] == 2'b11)
        |=> $stable(ctrl_rd[i]));

    // R6: an expiry shows up in the raw status one edge later
    a_r6_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> raw_stat[i]);

    // R7: an acknowledge with no expiry in the same cycle clears the bit
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFF_ACK && bus_wdata[i] && !expire[i])
        |=> !raw_stat[i]);
  end

endmodule

bind dual_interval_timer dit_checker #(.N_TMR(N_TMR)) u_dit_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .tick_src_i (tick_src_i),
  .expire     (expire),
  .raw_stat   (raw_stat),
  .ctrl_rd    (ctrl_rd)
);

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;

  localparam int CLK_P = 10;
  localparam int NV    = 8;

  logic        clk;
  logic        rst_n;
  logic [7:0]  tick_src_i;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_cmp;
  int n_err;
  bit done;

  dual_interval_timer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_src_i (tick_src_i),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_o      (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // {write, address, data, expected readback}
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 7'h00, 32'h0000_1234, 32'h0000_1234},  // R9 reload 0
    {1'b1, 7'h14, 32'hABCD_0001, 32'hABCD_0001},  // R9 reload 1
    {1'b1, 7'h04, 32'hFFFF_FFF5, 32'h0000_0015},  // R9 ctrl 0, sel 5 hold
    {1'b1, 7'h04, 32'h0000_0017, 32'h0000_0015},  // R4 op 3 discarded
    {1'b1, 7'h48, 32'hFFFF_FFFF, 32'h0000_0003},  // R9 mask width
    {1'b1, 7'h48, 32'h0000_0000, 32'h0000_0000},  // R9 mask clear
    {1'b0, 7'h30, 32'h0000_0000, 32'h0000_0000},  // R9 unmapped
    {1'b1, 7'h4C, 32'h0000_0003, 32'h0000_0000}   // R9 ack reads zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      tick_src_i[s] = 1'b1;
      @(negedge clk);
      tick_src_i = '0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    n_cmp = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; tick_src_i = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(7'h00, v); chk("R1 reload0", v, 0);
    rd(7'h04, v); chk("R1 ctrl0", v, 0);
    rd(7'h50, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // register vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71]) wr(VEC[i][70:64], VEC[i][63:32]);
      rd(VEC[i][70:64], v);
      chk($sformatf("R9 vector %0d", i), v, VEC[i][31:0]);
    end

    // R5 period after load, R8 masking
    wr(7'h00, 32'd3);
    wr(7'h04, 32'h14);          // sel 5, load
    wr(7'h04, 32'h16);          // sel 5, run
    tick(5, 2);
    rd(7'h50, v); chk("R5 no expiry before D", v, 0);
    tick(5, 1);
    rd(7'h50, v); chk("R5 R6 expiry on D-th tick", v, 1);
    chk("R8 masked off", {31'b0, irq_o}, 0);
    wr(7'h48, 32'h1);
    #1; chk("R8 mask on", {31'b0, irq_o}, 1);

    // R7 acknowledge
    wr(7'h4C, 32'h0);
    rd(7'h50, v); chk("R7 ack zero no effect", v, 1);
    wr(7'h4C, 32'h1);
    rd(7'h50, v); chk("R7 ack clears", v, 0);
    chk("R8 irq drops", {31'b0, irq_o}, 0);

    // R5 periodic reload
    tick(5, 2);
    rd(7'h50, v); chk("R5 reload not early", v, 0);
    tick(5, 1);
    rd(7'h50, v); chk("R5 periodic expiry", v, 1);
    wr(7'h4C, 32'h1);

    // R3 other sources ignored
    tick(7, 5);
    rd(7'h50, v); chk("R3 wrong source", v, 0);
    tick(5, 3);
    rd(7'h50, v); chk("R3 chosen source", v, 1);
    wr(7'h4C, 32'h1);

    // R10 hold keeps count
    tick(5, 1);                 // count 2
    wr(7'h04, 32'h15);          // hold
    tick(5, 4);
    rd(7'h50, v); chk("R2 hold stops", v, 0);
    wr(7'h04, 32'h16);          // run
    tick(5, 1);
    rd(7'h50, v); chk("R10 resume not early", v, 0);
    tick(5, 1);
    rd(7'h50, v); chk("R10 resume from held count", v, 1);
    wr(7'h4C, 32'h1);

    // R4 command 3 while running
    wr(7'h04, 32'h17);
    rd(7'h04, v); chk("R4 ctrl unchanged", v, 32'h16);
    tick(5, 3);
    rd(7'h50, v); chk("R4 still running", v, 1);
    wr(7'h4C, 32'h1);

    // R6 timer 1 sets bit 1, R5 with D=1
    wr(7'h14, 32'd1);
    wr(7'h18, 32'h1C);          // sel 7, load
    wr(7'h18, 32'h1E);          // sel 7, run
    tick(7, 1);
    rd(7'h50, v); chk("R6 timer1 bit", v, 2);
    wr(7'h48, 32'h3);
    #1; chk("R8 irq from timer1", {31'b0, irq_o}, 1);
    wr(7'h4C, 32'h2);
    wr(7'h18, 32'h1D);          // stop timer 1

    // R7 expiry wins over acknowledge
    tick(5, 3);
    rd(7'h50, v); chk("R6 bit0 set before collision", v, 1);
    tick(5, 2);                 // count 1
    bus_we = 1'b1; bus_addr = 7'h4C; bus_wdata = 32'h1; tick_src_i[5] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_src_i = '0;
    rd(7'h50, v); chk("R7 expiry wins collision", v, 1);
    wr(7'h4C, 32'h1);
    rd(7'h50, v); chk("R7 later ack clears", v, 0);

    // R1 reset mid-run
    tick(5, 3);
    #1; chk("R1 irq before reset", {31'b0, irq_o}, 1);
    rst_n = 1'b0;
    rd(7'h50, v); chk("R1 status after reset", v, 0);
    chk("R1 irq after reset", {31'b0, irq_o}, 0);
    rd(7'h48, v); chk("R1 mask after reset", v, 0);
    rd(7'h14, v); chk("R1 reload1 after reset", v, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tick(5, 10);
    rd(7'h50, v); chk("R1 timers stopped", v, 0);

    finish_run();
  end

endmodule